// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Flagged Receive Queue

This block recovers characters from an asynchronous serial line. A free-running divider makes a sampling strobe at sixteen times the bit rate. A small state machine uses that strobe to find the start of each character, sample every bit, and check the optional parity bit and the stop bit. The line is brought into the clock domain through a two-stage synchronizer before any sampling takes place.

Every finished character goes into a first-in first-out queue. Each queue entry holds the character and four error flags: line break, lost character (overrun), parity mismatch and bad stop bit. Logic on the register side pops one entry per read strobe. Two status outputs report whether the queue is empty or full. The character length (5 to 8 bits) and the parity mode come from static configuration inputs. They are changed only while the line is idle.

Top module: `serial_rx_queue`

## Requirements
- R1: Data bits are taken least significant bit first at the centre of each bit cell. `cfg_len` selects the length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8. `rd_data` bits above the selected length read 0.
- R2: A falling edge starts a character only if the line is still low 8 sampling strobes later. A low pulse shorter than half a bit queues nothing.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_odd` = 0 selects even parity (data bits plus the parity bit hold an even number of ones) and 1 selects odd parity. A mismatch sets `rd_parity_err`. With parity disabled the flag is always 0.
- R4: If the stop bit is sampled low at its centre, the character is queued with `rd_frame_err` = 1 once the line is seen high again.
- R5: If the line stays low for more than one full character time (start, data, parity and stop bits, times 16 strobes), a single entry is queued with `rd_break` = 1, `rd_frame_err` = 1, `rd_parity_err` = 0 and data 0. Nothing more is queued until the line goes high.
- R6: The queue holds DEPTH entries (16 by default) and returns them in arrival order. `rx_empty` is 1 exactly when no entry is stored. `rx_full` is 1 exactly when DEPTH entries are stored. The two are never 1 together.
- R7: A character that completes while the queue is full is dropped and the stored entries are unchanged. The next entry that is stored carries `rd_overrun` = 1. Later entries carry 0.
- R8: When `rd_en` is high and the queue is not empty, the oldest entry appears on the read outputs with `rd_valid` = 1 in the next cycle. A `rd_en` while the queue is empty produces no `rd_valid` and changes nothing.
- R9: After the synchronous active-high reset, `rx_empty` = 1, `rx_full` = 0 and `rd_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Asynchronous serial line; idles high |
| cfg_len | input | 2 | Character length code (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| rd_en | input | 1 | Pop strobe for the receive queue |
| rd_valid | output | 1 | Read outputs hold a popped entry this cycle |
| rd_data | output | 8 | Received character, right aligned |
| rd_parity_err | output | 1 | Parity mismatch flag of the popped entry |
| rd_frame_err | output | 1 | Bad stop bit flag of the popped entry |
| rd_break | output | 1 | Line break flag of the popped entry |
| rd_overrun | output | 1 | A character was lost just before this entry |
| rx_empty | output | 1 | 1 when the queue holds no entry |
| rx_full | output | 1 | 1 when the queue holds DEPTH entries |

## Verification
The bench builds the block with a divider of 4 clocks per sampling strobe. That makes a bit cell 64 cycles long, so even break-length lows and seventeen back-to-back characters fit in a short run. The queue keeps its default depth of 16, so the bench can reach the full status and the overrun drop with real traffic and check the flag on the entry that follows. All four length codes and both parity senses are exercised, with correct and deliberately wrong parity and stop bits.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int OSR = 16;
  localparam int CHAR_MAX = 8;

  typedef struct packed {
    logic       brk;
    logic       ovr;
    logic       perr;
    logic       ferr;
    logic [7:0] data;
  } srq_entry_t;

  localparam int ENTRY_W = $bits(srq_entry_t);

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD,
    RX_WAITHI
  } rx_state_t;
endpackage

// File: rtl/srq_tick_div.sv
module srq_tick_div #(
  parameter int DIV = 54
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/srq_deframer.sv
module srq_deframer
  import srq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  output logic       push,
  output srq_entry_t push_entry
);
  localparam int TW = $clog2(OSR);
  localparam int MAX_FRAME = OSR * (CHAR_MAX + 3);
  localparam int LW = $clog2(MAX_FRAME + 2);
  localparam logic [TW-1:0] MID = TW'(OSR / 2 - 1);
  localparam logic [TW-1:0] END = TW'(OSR - 1);
  localparam logic [LW-1:0] LMAX = '1;

  rx_state_t     st;
  logic [TW-1:0] tcnt;
  logic [2:0]    bidx;
  logic [7:0]    sh;
  logic          perr_r;
  logic [LW-1:0] lowcnt;
  logic [LW-1:0] frame_ticks;
  logic [7:0]    data_al;
  logic [2:0]    last_idx;

  always_comb begin
    data_al     = sh >> (2'd3 - cfg_len);
    last_idx    = 3'd4 + {1'b0, cfg_len};
    frame_ticks = LW'(OSR * (7 + int'(cfg_len) + int'(cfg_par_en)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= RX_IDLE;
      tcnt       <= '0;
      bidx       <= '0;
      sh         <= '0;
      perr_r     <= 1'b0;
      lowcnt     <= '0;
      push       <= 1'b0;
      push_entry <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        if (line) lowcnt <= '0;
        else if (lowcnt != LMAX) lowcnt <= lowcnt + 1'b1;

        case (st)
          RX_IDLE: begin
            if (!line) begin
              st   <= RX_START;
              tcnt <= '0;
            end
          end
          RX_START: begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == MID) begin
              if (!line) begin
                st     <= RX_DATA;
                tcnt   <= '0;
                bidx   <= '0;
                sh     <= '0;
                perr_r <= 1'b0;
              end else begin
                st <= RX_IDLE;
              end
            end
          end
          RX_DATA: begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == END) begin
              sh   <= {line, sh[7:1]};
              bidx <= bidx + 1'b1;
              if (bidx == last_idx) st <= cfg_par_en ? RX_PAR : RX_STOP;
            end
          end
          RX_PAR: begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == END) begin
              perr_r <= (^data_al) ^ line ^ cfg_par_odd;
              st     <= RX_STOP;
            end
          end
          RX_STOP: begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == END) begin
              if (line) begin
                push       <= 1'b1;
                push_entry <= '{brk: 1'b0, ovr: 1'b0, perr: perr_r,
                               ferr: 1'b0, data: data_al};
                st         <= RX_IDLE;
              end else begin
                st <= RX_HOLD;
              end
            end
          end
          RX_HOLD: begin
            if (line) begin
              push       <= 1'b1;
              push_entry <= '{brk: 1'b0, ovr: 1'b0, perr: perr_r,
                             ferr: 1'b1, data: data_al};
              st         <= RX_IDLE;
            end else if (lowcnt > frame_ticks) begin
              push       <= 1'b1;
              push_entry <= '{brk: 1'b1, ovr: 1'b0, perr: 1'b0,
                             ferr: 1'b1, data: 8'h00};
              st         <= RX_WAITHI;
            end
          end
          RX_WAITHI: begin
            if (line) st <= RX_IDLE;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srq_fifo.sv
module srq_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic                       rd_valid,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_n, rptr_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          wr_ok, rd_ok;

  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;
  assign fill  = cnt;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wptr_n = wptr + 1'b1;
      assign rptr_n = rptr + 1'b1;
    end else begin : g_wrap
      assign wptr_n = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rptr_n = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_n = cnt;
    if (wr_ok && !rd_ok) cnt_n = cnt + 1'b1;
    else if (rd_ok && !wr_ok) cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      empty    <= 1'b1;
      full     <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_ok) wptr <= wptr_n;
      if (rd_ok) rptr <= rptr_n;
      cnt      <= cnt_n;
      empty    <= (cnt_n == '0);
      full     <= (cnt_n == CMAX);
      rd_valid <= rd_ok;
    end
  end
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import srq_pkg::*;
#(
  parameter int DIV   = 54,
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxd,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       rd_en,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_parity_err,
  output logic       rd_frame_err,
  output logic       rd_break,
  output logic       rd_overrun,
  output logic       rx_empty,
  output logic       rx_full
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          tick;
  logic [1:0]    sync_q;
  logic          frame_push;
  srq_entry_t    frame_entry;
  srq_entry_t    store_entry;
  srq_entry_t    head;
  logic          ovr_pend;
  logic [CW-1:0] fifo_fill;

  srq_tick_div #(.DIV(DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rxd};
  end

  srq_deframer u_rx (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .line        (sync_q[1]),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .push        (frame_push),
    .push_entry  (frame_entry)
  );

  always_ff @(posedge clk) begin
    if (rst) ovr_pend <= 1'b0;
    else if (frame_push) ovr_pend <= rx_full;
  end

  always_comb begin
    store_entry     = frame_entry;
    store_entry.ovr = ovr_pend;
  end

  srq_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_q (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (frame_push),
    .wr_data  (store_entry),
    .rd_en    (rd_en),
    .rd_data  (head),
    .rd_valid (rd_valid),
    .empty    (rx_empty),
    .full     (rx_full),
    .fill     (fifo_fill)
  );

  assign rd_data       = head.data;
  assign rd_parity_err = head.perr;
  assign rd_frame_err  = head.ferr;
  assign rd_break      = head.brk;
  assign rd_overrun    = head.ovr;
endmodule

// File: rtl/srq_checker.sv
module srq_checker #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       rd_en,
  input logic                       rd_valid,
  input logic                       rx_empty,
  input logic                       rx_full,
  input logic                       push,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  a_r6_not_both: assert property (@(posedge clk) disable iff (rst)
    !(rx_empty && rx_full));

  a_r6_full_tracks_fill: assert property (@(posedge clk) disable iff (rst)
    rx_full == (int'(fill) == DEPTH));

  a_r7_full_drop_keeps: assert property (@(posedge clk) disable iff (rst)
    (push && rx_full && !rd_en) |=> (rx_full && fill == $past(fill)));

  a_r8_valid_after_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en && !rx_empty));

  a_r8_empty_read_idle: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rx_empty) |=> !rd_valid);

  a_r9_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rx_empty && !rx_full && !rd_valid));
endmodule

bind serial_rx_queue srq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rd_en    (rd_en),
  .rd_valid (rd_valid),
  .rx_empty (rx_empty),
  .rx_full  (rx_full),
  .push     (frame_push),
  .fill     (fifo_fill)
);

// File: tb/serial_rx_queue_test.sv
module serial_rx_queue_test;
  localparam int DIV   = 4;
  localparam int DEPTH = 16;
  localparam int BIT   = 16 * DIV;
  localparam int NV    = 8;
  // {len[15:14], par_en[13], par_odd[12], flip_parity[11], bad_stop[10], 2'b0, data[7:0]}
  localparam logic [15:0] VEC [NV] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'b0, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b0, 8'hFF},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b0, 8'h2D},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 2'b0, 8'h55},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 2'b0, 8'h81},
    {2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 2'b0, 8'h3C},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 2'b0, 8'hC3},
    {2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b0, 8'h11}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_valid, rd_parity_err, rd_frame_err, rd_break, rd_overrun;
  logic       rx_empty, rx_full;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;

  logic       g_valid, g_pe, g_fe, g_brk, g_ovr;
  logic [7:0] g_data;

  always #5 clk = ~clk;

  serial_rx_queue #(.DIV(DIV), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .rxd(rxd), .cfg_len(cfg_len),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_parity_err(rd_parity_err),
    .rd_frame_err(rd_frame_err), .rd_break(rd_break), .rd_overrun(rd_overrun),
    .rx_empty(rx_empty), .rx_full(rx_full)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int cycles);
    rxd = v;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] len, input logic pen, input logic podd,
                      input logic flip, input logic bad, input logic [7:0] d);
    int n;
    logic p;
    n = 5 + int'(len);
    p = podd ^ flip;
    hold_line(1'b0, BIT);
    for (int i = 0; i < n; i++) begin
      hold_line(d[i], BIT);
      p = p ^ d[i];
    end
    if (pen) hold_line(p, BIT);
    if (bad) hold_line(1'b0, BIT);
    hold_line(1'b1, 3 * BIT);
  endtask

  task automatic pop();
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    g_valid = rd_valid;
    g_data  = rd_data;
    g_pe    = rd_parity_err;
    g_fe    = rd_frame_err;
    g_brk   = rd_break;
    g_ovr   = rd_overrun;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 empty after reset", 32'(rx_empty), 32'd1);
    chk("R9 full after reset", 32'(rx_full), 32'd0);
    chk("R9 valid after reset", 32'(rd_valid), 32'd0);

    // R8: read on empty queue yields nothing
    pop();
    chk("R8 empty read valid", 32'(g_valid), 32'd0);
    chk("R8 empty read status", 32'(rx_empty), 32'd1);

    // table walk: R1 R3 R4
    for (int k = 0; k < NV; k++) begin
      logic [7:0] mask, expd;
      logic       pe_exp;
      cfg_len     = VEC[k][15:14];
      cfg_par_en  = VEC[k][13];
      cfg_par_odd = VEC[k][12];
      mask   = 8'hFF >> (3 - int'(VEC[k][15:14]));
      expd   = VEC[k][7:0] & mask;
      pe_exp = VEC[k][13] & VEC[k][11];
      send(VEC[k][15:14], VEC[k][13], VEC[k][12], VEC[k][11], VEC[k][10], VEC[k][7:0]);
      chk("R6 non-empty after char", 32'(rx_empty), 32'd0);
      pop();
      chk("R8 valid on read", 32'(g_valid), 32'd1);
      chk("R1 data", 32'(g_data), 32'(expd));
      chk("R3 parity flag", 32'(g_pe), 32'(pe_exp));
      chk("R4 frame flag", 32'(g_fe), 32'(VEC[k][10]));
      chk("R5 break clear on normal char", 32'(g_brk), 32'd0);
    end

    // R2: short glitch is not a start bit
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
    hold_line(1'b0, 3 * DIV);
    hold_line(1'b1, 3 * BIT);
    chk("R2 glitch ignored", 32'(rx_empty), 32'd1);

    // R5: long low line is one break entry
    hold_line(1'b0, 15 * BIT);
    hold_line(1'b1, 3 * BIT);
    pop();
    chk("R5 break valid", 32'(g_valid), 32'd1);
    chk("R5 break flag", 32'(g_brk), 32'd1);
    chk("R5 break frame flag", 32'(g_fe), 32'd1);
    chk("R5 break data", 32'(g_data), 32'd0);
    chk("R5 single break entry", 32'(rx_empty), 32'd1);

    // R6/R7: fill, overrun, order
    for (int k = 0; k < DEPTH; k++) send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'(k * 7 + 3));
    chk("R6 full at depth", 32'(rx_full), 32'd1);
    chk("R6 not empty at depth", 32'(rx_empty), 32'd0);
    send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'hAA);
    chk("R7 still full after drop", 32'(rx_full), 32'd1);
    for (int k = 0; k < DEPTH; k++) begin
      pop();
      chk("R6 order", 32'(g_data), 32'(8'(k * 7 + 3)));
      chk("R7 no overrun on kept entries", 32'(g_ovr), 32'd0);
    end
    chk("R6 empty after drain", 32'(rx_empty), 32'd1);
    send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C);
    send(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h4B);
    pop();
    chk("R7 next entry data", 32'(g_data), 32'h3C);
    chk("R7 overrun flag set", 32'(g_ovr), 32'd1);
    pop();
    chk("R7 later entry data", 32'(g_data), 32'h4B);
    chk("R7 overrun flag cleared", 32'(g_ovr), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule